// File: doc/BRIEF.md
# Two-Wire Debug Frame Master

This block is the host side of a two-wire debug and programming link. It has one clock line that only the host drives and one data line that either side may drive. A local requester hands the block one request at a time. The block turns each request into a single frame on the link and answers with a one-cycle completion pulse. A read frame also returns a byte, and a failed handshake returns an error flag.

There are four frame kinds: address-register write, address-register read, data-register write and data-register read. A fifth request asks for a target reset, which the block signals by holding the clock line low for a long time. Every frame is built from clock strobes. A strobe is a low pulse followed by a high rest. Both widths are whole numbers of a tick, and the tick comes from a system-clock prescaler, so the same logic can serve any system frequency. The data line is driven or released through an output-enable signal, and the block samples the line at the end of each strobe.

Top module: `dbg2w_master`

## Requirements
- R1: After reset and whenever `req_ready` is high, the link clock rests high and `lnk_d_oe` is low.
- R2: Every frame starts with one strobe during which the data line is released (`lnk_d_oe`=0). Every frame that completes normally ends with one such strobe. Data output and enable change only while the link clock is high.
- R3: After the first strobe, the host drives the 2-bit instruction code `req_op[1:0]` over two strobes, bit 0 first. The codes are: address write 2'b11, address read 2'b10, data write 2'b01, data read 2'b00.
- R4: An address write drives the 8 bits of `req_data`, bit 0 first. An address read releases the line for 8 strobes, and the value sampled after the k-th of these strobes becomes bit k of `rd_data`.
- R5: Data frames (codes 2'b01 and 2'b00) drive two strobes of 0 as the length field, straight after the instruction code.
- R6: A data write drives `req_data` bit 0 first and then releases the line for the wait field. A data read runs the wait field first and then samples 8 bits, bit 0 first, into `rd_data`.
- R7: In the wait field the line is released and one strobe is given per sample. The field ends at the first strobe after which the line reads 1. If the line still reads 0 after WAIT_LIMIT (20) strobes, the frame ends with no closing strobe, `done` is raised with `err`=1, and `rd_data`=0.
- R8: A normal strobe holds the clock low for exactly LOW_TICKS*TICK_DIV system cycles, then high for at least HIGH_TICKS*TICK_DIV cycles.
- R9: A request with `req_op[2]`=1 produces one low pulse of exactly RESET_TICKS*TICK_DIV cycles with the data line released, then completes with `err`=0.
- R10: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` stays low from acceptance until `done`. `done` is a single-cycle pulse, and `rd_data` and `err` are valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request can be accepted |
| req_op | input | 3 | Bit 2 = target reset; bits 1:0 = instruction code |
| req_data | input | 8 | Byte to send for write frames |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 8 | Byte read by the completed frame (0 otherwise) |
| err | output | 1 | Completed frame hit the wait-field timeout |
| lnk_clk | output | 1 | Link clock line |
| lnk_d_out | output | 1 | Value driven onto the link data line |
| lnk_d_oe | output | 1 | Data line drive enable |
| lnk_d_in | input | 1 | Sampled level of the link data line |

## Verification
The checks assume the requester keeps `req_valid` low while a frame is in progress. They also assume the target changes the data line only while the host has it released. Under those conditions, the data enable and value never move during a clock-low phase, and no low phase reaches the reset length. The stimulus raises `req_valid` for one cycle, and only after seeing `req_ready` high. The modelled target updates its data bit only on a rising link-clock edge, and the bench feeds the line back through the enable so that host and target never contend.

// File: rtl/dbg2w_pkg.sv
package dbg2w_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_START,
    S_INS,
    S_LEN,
    S_WBITS,
    S_RBITS,
    S_WAIT,
    S_STOP,
    S_RESET
  } seq_state_t;

  typedef enum logic [1:0] {
    P_IDLE,
    P_LOW,
    P_HIGH
  } pulse_phase_t;

endpackage

// File: rtl/dbg2w_tick.sv
module dbg2w_tick #(
  parameter int TICK_DIV = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic sync,
  output logic tick
);
  localparam int W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  logic [W-1:0] cnt;

  assign tick = (cnt == W'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || sync) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/dbg2w_pulse.sv
module dbg2w_pulse
  import dbg2w_pkg::*;
#(
  parameter int LOW_TICKS   = 1,
  parameter int HIGH_TICKS  = 1,
  parameter int RESET_TICKS = 25
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic long_low,
  input  logic tick,
  output logic sync,
  output logic clk_line,
  output logic fin
);
  localparam int M1   = (LOW_TICKS > HIGH_TICKS) ? LOW_TICKS : HIGH_TICKS;
  localparam int MAXT = (RESET_TICKS > M1) ? RESET_TICKS : M1;
  localparam int CW   = $clog2(MAXT + 1);

  pulse_phase_t phase;
  logic [CW-1:0] cnt;

  // restart the prescaler so the low phase is an exact number of ticks
  assign sync = go && (phase == P_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= P_IDLE;
      cnt      <= '0;
      clk_line <= 1'b1;
      fin      <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (phase)
        P_IDLE: if (go) begin
          phase    <= P_LOW;
          clk_line <= 1'b0;
          cnt      <= long_low ? CW'(RESET_TICKS - 1) : CW'(LOW_TICKS - 1);
        end
        P_LOW: if (tick) begin
          if (cnt == '0) begin
            phase    <= P_HIGH;
            clk_line <= 1'b1;
            cnt      <= CW'(HIGH_TICKS - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        P_HIGH: if (tick) begin
          if (cnt == '0) begin
            phase <= P_IDLE;
            fin   <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= P_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbg2w_seq.sv
module dbg2w_seq
  import dbg2w_pkg::*;
#(
  parameter int WAIT_LIMIT = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  input  logic [2:0] req_op,
  input  logic [7:0] req_data,
  output logic       req_ready,
  input  logic       fin,
  input  logic       din,
  output logic       go,
  output logic       long_low,
  output logic       dout,
  output logic       doe,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       err
);
  localparam int WW = (WAIT_LIMIT > 1) ? $clog2(WAIT_LIMIT) : 1;

  seq_state_t    state;
  logic [1:0]    code;
  logic [7:0]    sh;
  logic [2:0]    bcnt;
  logic [WW-1:0] wcnt;

  assign req_ready = (state == S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= S_IDLE;
      code     <= 2'b00;
      sh       <= 8'h00;
      bcnt     <= 3'd0;
      wcnt     <= '0;
      go       <= 1'b0;
      long_low <= 1'b0;
      dout     <= 1'b0;
      doe      <= 1'b0;
      done     <= 1'b0;
      rd_data  <= 8'h00;
      err      <= 1'b0;
    end else begin
      go   <= 1'b0;
      done <= 1'b0;
      if (state == S_IDLE) begin
        if (req_valid) begin
          code     <= req_op[1:0];
          sh       <= req_data;
          go       <= 1'b1;
          long_low <= req_op[2];
          doe      <= 1'b0;
          state    <= req_op[2] ? S_RESET : S_START;
        end
      end else if (fin) begin
        case (state)
          S_START: begin
            state <= S_INS;
            bcnt  <= 3'd0;
            doe   <= 1'b1;
            dout  <= code[0];
            go    <= 1'b1;
          end
          S_INS: begin
            go <= 1'b1;
            if (bcnt == 3'd0) begin
              bcnt <= 3'd1;
              dout <= code[1];
            end else begin
              bcnt <= 3'd0;
              if (code[1]) begin
                if (code[0]) begin
                  state <= S_WBITS;
                  dout  <= sh[0];
                end else begin
                  state <= S_RBITS;
                  doe   <= 1'b0;
                end
              end else begin
                state <= S_LEN;
                dout  <= 1'b0;
              end
            end
          end
          S_LEN: begin
            go <= 1'b1;
            if (bcnt == 3'd0) begin
              bcnt <= 3'd1;
              dout <= 1'b0;
            end else begin
              bcnt <= 3'd0;
              if (code[0]) begin
                state <= S_WBITS;
                dout  <= sh[0];
              end else begin
                state <= S_WAIT;
                doe   <= 1'b0;
                wcnt  <= '0;
              end
            end
          end
          S_WBITS: begin
            go <= 1'b1;
            sh <= {1'b0, sh[7:1]};
            if (bcnt == 3'd7) begin
              bcnt  <= 3'd0;
              doe   <= 1'b0;
              wcnt  <= '0;
              state <= code[1] ? S_STOP : S_WAIT;
            end else begin
              bcnt <= bcnt + 3'd1;
              dout <= sh[1];
            end
          end
          S_RBITS: begin
            go <= 1'b1;
            sh <= {din, sh[7:1]};
            if (bcnt == 3'd7) begin
              bcnt  <= 3'd0;
              state <= S_STOP;
            end else begin
              bcnt <= bcnt + 3'd1;
            end
          end
          S_WAIT: begin
            if (din) begin
              go    <= 1'b1;
              bcnt  <= 3'd0;
              state <= code[0] ? S_STOP : S_RBITS;
            end else if (wcnt == WW'(WAIT_LIMIT - 1)) begin
              done    <= 1'b1;
              err     <= 1'b1;
              rd_data <= 8'h00;
              state   <= S_IDLE;
            end else begin
              wcnt <= wcnt + 1'b1;
              go   <= 1'b1;
            end
          end
          S_STOP: begin
            done    <= 1'b1;
            err     <= 1'b0;
            rd_data <= code[0] ? 8'h00 : sh;
            state   <= S_IDLE;
          end
          S_RESET: begin
            done    <= 1'b1;
            err     <= 1'b0;
            rd_data <= 8'h00;
            state   <= S_IDLE;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbg2w_master.sv
module dbg2w_master #(
  parameter int TICK_DIV    = 100,
  parameter int LOW_TICKS   = 1,
  parameter int HIGH_TICKS  = 1,
  parameter int RESET_TICKS = 25,
  parameter int WAIT_LIMIT  = 20
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic [2:0] req_op,
  input  logic [7:0] req_data,
  output logic       done,
  output logic [7:0] rd_data,
  output logic       err,
  output logic       lnk_clk,
  output logic       lnk_d_out,
  output logic       lnk_d_oe,
  input  logic       lnk_d_in
);
  logic tick, sync, go, long_low, fin;

  dbg2w_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .sync (sync),
    .tick (tick)
  );

  dbg2w_pulse #(
    .LOW_TICKS  (LOW_TICKS),
    .HIGH_TICKS (HIGH_TICKS),
    .RESET_TICKS(RESET_TICKS)
  ) u_pulse (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .long_low (long_low),
    .tick     (tick),
    .sync     (sync),
    .clk_line (lnk_clk),
    .fin      (fin)
  );

  dbg2w_seq #(.WAIT_LIMIT(WAIT_LIMIT)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_data (req_data),
    .req_ready(req_ready),
    .fin      (fin),
    .din      (lnk_d_in),
    .go       (go),
    .long_low (long_low),
    .dout     (lnk_d_out),
    .doe      (lnk_d_oe),
    .done     (done),
    .rd_data  (rd_data),
    .err      (err)
  );
endmodule

// File: rtl/dbg2w_checker.sv
module dbg2w_checker #(
  parameter int TICK_DIV    = 100,
  parameter int RESET_TICKS = 25
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic err,
  input logic lnk_clk,
  input logic lnk_d_out,
  input logic lnk_d_oe
);
  int unsigned lowcnt;

  always_ff @(posedge clk) begin
    if (rst) lowcnt <= 0;
    else     lowcnt <= lnk_clk ? 0 : lowcnt + 1;
  end

  assert_idle_lines_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (lnk_clk && !lnk_d_oe));

  assert_line_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !lnk_clk |-> ($stable(lnk_d_oe) && $stable(lnk_d_out)));

  assert_err_with_done_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(err) |-> done);

  assert_low_bound_R8: assert property (@(posedge clk) disable iff (rst)
    !lnk_clk |-> (lowcnt < RESET_TICKS * TICK_DIV));

  assert_accept_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);
endmodule

bind dbg2w_master dbg2w_checker #(
  .TICK_DIV   (TICK_DIV),
  .RESET_TICKS(RESET_TICKS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .err      (err),
  .lnk_clk  (lnk_clk),
  .lnk_d_out(lnk_d_out),
  .lnk_d_oe (lnk_d_oe)
);

// File: tb/dbg2w_master_test.sv
module dbg2w_master_test;
  localparam int TD = 2, LT = 2, HT = 2, RT = 12, WL = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = 3'd0;
  logic [7:0] req_data = 8'h00;
  logic req_ready, done, err, lnk_clk, lnk_d_out, lnk_d_oe, lnk_d_in;
  logic [7:0] rd_data;

  logic tgt_bit;
  logic mon_clr = 1'b0;
  logic resp [64];
  logic rec_oe [64];
  logic rec_do [64];
  logic exp_oe [64];
  logic exp_do [64];
  int exp_n;
  int nstr, lrun, hrun, min_low, max_low, min_high;
  logic prev_clk;
  int nchk = 0, nerr = 0;
  logic [7:0] got_data;
  logic got_err, busy_seen;
  bit finished = 0;

  always #2 clk = ~clk;

  assign lnk_d_in = lnk_d_oe ? lnk_d_out : tgt_bit;

  dbg2w_master #(.TICK_DIV(TD), .LOW_TICKS(LT), .HIGH_TICKS(HT),
                 .RESET_TICKS(RT), .WAIT_LIMIT(WL)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_data(req_data), .done(done), .rd_data(rd_data),
    .err(err), .lnk_clk(lnk_clk), .lnk_d_out(lnk_d_out),
    .lnk_d_oe(lnk_d_oe), .lnk_d_in(lnk_d_in));

  // target model and link monitor
  always @(posedge clk) begin
    prev_clk <= lnk_clk;
    lrun <= lnk_clk ? 0 : lrun + 1;
    hrun <= lnk_clk ? hrun + 1 : 0;
    if (mon_clr) begin
      nstr <= 0; min_low <= 9999; max_low <= 0; min_high <= 9999;
      tgt_bit <= 1'b1;
    end else if (lnk_clk !== prev_clk && !rst) begin
      if (!lnk_clk) begin
        if (nstr < 64) begin
          rec_oe[nstr] <= lnk_d_oe;
          rec_do[nstr] <= lnk_d_out;
        end
        if (nstr > 0 && hrun < min_high) min_high <= hrun;
      end else begin
        tgt_bit <= (nstr < 64) ? resp[nstr] : 1'b1;
        nstr <= nstr + 1;
        if (lrun < min_low) min_low <= lrun;
        if (lrun > max_low) max_low <= lrun;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic resp_fill(input logic v);
    for (int i = 0; i < 64; i++) resp[i] = v;
  endtask

  task automatic exp_clear();
    exp_n = 0;
  endtask

  task automatic exp_push(input logic oe, input logic d);
    exp_oe[exp_n] = oe; exp_do[exp_n] = d; exp_n++;
  endtask

  task automatic exp_byte(input logic [7:0] v, input logic oe);
    for (int i = 0; i < 8; i++) exp_push(oe, v[i]);
  endtask

  task automatic cmp_frame(input string tag);
    int bad;
    bad = -1;
    check(nstr == exp_n, {tag, " strobe count"}, nstr, exp_n);
    for (int i = 0; i < exp_n && i < 64; i++)
      if (bad < 0 && (rec_oe[i] !== exp_oe[i] ||
                      (exp_oe[i] && rec_do[i] !== exp_do[i]))) bad = i;
    check(bad < 0, {tag, " field sequence (first bad strobe)"}, bad, -1);
  endtask

  task automatic run_req(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk); mon_clr = 1'b1;
    @(negedge clk); mon_clr = 1'b0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    busy_seen = !req_ready;
    while (!done) @(negedge clk);
    got_data = rd_data; got_err = err;
    @(negedge clk);
    check(!done && req_ready, "R10 done lasts one cycle, ready after", done, 0);
    check(busy_seen, "R10 ready low after accept", busy_seen, 1);
  endtask

  task automatic t_reset_state();
    check(lnk_clk === 1'b1, "R1 clock high after reset", lnk_clk, 1);
    check(lnk_d_oe === 1'b0, "R1 data released after reset", lnk_d_oe, 0);
    check(req_ready === 1'b1 && done === 1'b0, "R1 ready, no done after reset", req_ready, 1);
  endtask

  task automatic t_addr_write();
    resp_fill(1'b1);
    run_req(3'b011, 8'hA5);
    exp_clear(); exp_push(0, 0); exp_push(1, 1); exp_push(1, 1);
    exp_byte(8'hA5, 1); exp_push(0, 0);
    cmp_frame("R2 R3 R4 addr write");
    check(!got_err, "R4 addr write no error", got_err, 0);
    check(min_low == LT*TD && max_low == LT*TD, "R8 low width", max_low, LT*TD);
    check(min_high >= HT*TD, "R8 high width", min_high, HT*TD);
    check(lnk_clk && !lnk_d_oe, "R1 idle after frame", lnk_d_oe, 0);
  endtask

  task automatic t_addr_read();
    logic [7:0] v = 8'h3C;
    resp_fill(1'b1);
    for (int i = 0; i < 8; i++) resp[3+i] = v[i];
    run_req(3'b010, 8'hFF);
    exp_clear(); exp_push(0, 0); exp_push(1, 0); exp_push(1, 1);
    exp_byte(8'h00, 0); exp_push(0, 0);
    cmp_frame("R3 R4 addr read");
    check(got_data == v, "R4 addr read data", got_data, v);
  endtask

  task automatic t_data_write_wait();
    resp_fill(1'b1);
    for (int i = 13; i < 16; i++) resp[i] = 1'b0;
    run_req(3'b001, 8'h5A);
    exp_clear(); exp_push(0, 0); exp_push(1, 1); exp_push(1, 0);
    exp_push(1, 0); exp_push(1, 0); exp_byte(8'h5A, 1);
    for (int i = 0; i < 4; i++) exp_push(0, 0);
    exp_push(0, 0);
    cmp_frame("R5 R6 R7 data write with 4 wait strobes");
    check(!got_err && got_data == 0, "R6 data write completes clean", got_err, 0);
  endtask

  task automatic t_data_read();
    logic [7:0] v = 8'hC3;
    resp_fill(1'b1);
    for (int i = 0; i < 8; i++) resp[6+i] = v[i];
    run_req(3'b000, 8'h00);
    exp_clear(); exp_push(0, 0); exp_push(1, 0); exp_push(1, 0);
    exp_push(1, 0); exp_push(1, 0); exp_push(0, 0);
    exp_byte(8'h00, 0); exp_push(0, 0);
    cmp_frame("R5 R6 data read, immediate wait");
    check(got_data == v && !got_err, "R6 data read value", got_data, v);
  endtask

  task automatic t_wait_timeout();
    resp_fill(1'b1);
    for (int i = 13; i < 64; i++) resp[i] = 1'b0;
    run_req(3'b001, 8'h77);
    check(nstr == 33, "R7 timeout after 20 wait strobes, no closing strobe", nstr, 33);
    check(got_err == 1'b1, "R7 timeout error flag", got_err, 1);
    check(lnk_clk && !lnk_d_oe, "R1 idle after abort", lnk_d_oe, 0);
  endtask

  task automatic t_wait_last();
    resp_fill(1'b1);
    for (int i = 13; i < 32; i++) resp[i] = 1'b0;
    run_req(3'b001, 8'h01);
    check(nstr == 34, "R7 ready on 20th wait strobe then closing strobe", nstr, 34);
    check(!got_err, "R7 no error on 20th strobe", got_err, 0);
  endtask

  task automatic t_read_timeout();
    resp_fill(1'b1);
    for (int i = 5; i < 64; i++) resp[i] = 1'b0;
    run_req(3'b000, 8'h00);
    check(nstr == 25, "R7 data read timeout strobes", nstr, 25);
    check(got_err && got_data == 0, "R7 data read timeout rd_data zero", got_data, 0);
  endtask

  task automatic t_target_reset();
    resp_fill(1'b1);
    run_req(3'b100, 8'h00);
    check(nstr == 1, "R9 single reset pulse", nstr, 1);
    check(max_low == RT*TD && min_low == RT*TD, "R9 reset low width", max_low, RT*TD);
    check(rec_oe[0] === 1'b0, "R9 data released during reset", rec_oe[0], 0);
    check(!got_err, "R9 reset completes without error", got_err, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_addr_write();
    t_addr_read();
    t_data_write_wait();
    t_data_read();
    t_wait_timeout();
    t_wait_last();
    t_read_timeout();
    t_target_reset();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog R10 run did not complete actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end
endmodule